// File: doc/BRIEF.md
# Dual-Function Capture/Compare Register Bank

This block is one timer channel built around a free-running 16-bit counter and four general registers. Each register is set by its own small control field to act either as an output-compare register, which watches the counter and acts on a pin when the two are equal, or as an input-capture register, which stores the counter value when a chosen edge arrives on its input pin. Each register has a status flag that records a match or a capture. Software clears the flag.

A 16-bit register bus gives access to the general registers, the packed control fields, the status flags and the counter. Only full-width writes are accepted. A separate PWM mode input overrides every control field. While it is high, each register is a compare register and its output pin shows the level "counter below register".

After reset every register is in compare mode with no pin action and holds 0xFFFF.

Top module: `ccr_bank`

## Requirements
- R1: After reset, general registers 0..3 (bus addresses 0..3) read 0xFFFF, the control word (address 4) reads 0x0000, the flags (address 5) read 0x0000, the counter (address 6) reads 0x0000 and all compare outputs are 0.
- R2: The counter advances by one on each clock edge where `cnt_en` is high and wraps from 0xFFFF to 0x0000. A full-width write to address 6 loads it, and the load takes priority over counting.
- R3: A write with `bus_full` high loads the addressed register. A write with `bus_full` low changes no register at all.
- R4: Register k acts as a compare register when PWM mode is on or when bit 4k+2 of the control word is 0. In that case, an edge with `cnt_en` high and the counter equal to the register sets flag k (flags bit k), which is visible on the next cycle.
- R5: In compare mode, control bits [4k+1:4k] select what a match does to `cmp_out[k]`: 00 leaves it unchanged, 01 drives 0, 10 drives 1 and 11 toggles it.
- R6: With control bit 4k+2 set, register k captures the counter value and sets flag k on a synchronised edge of `cap_in[k]`. Bits [4k+1:4k] select the edge: 00 is rising, 01 is falling, and 1x is both edges. An edge that was not selected captures nothing.
- R7: Each input edge causes exactly one capture. A level that stays put does not capture again while the counter moves.
- R8: A full-width write to address 5 clears each flag whose data bit is 0 and leaves each flag whose data bit is 1 unchanged.
- R9: When a flag-setting event and a clearing write to the same flag happen on the same edge, the flag ends up set.
- R10: While `pwm_mode` is high, control fields are ignored and captures do not happen. Each `cmp_out[k]` follows (counter < register k) with a one-cycle delay.
- R11: When a capture and a bus write hit the same register on the same edge, the captured counter value is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_en | input | 1 | Counter advance enable |
| pwm_mode | input | 1 | PWM override of the control fields |
| bus_we | input | 1 | Write strobe |
| bus_full | input | 1 | 1 = full 16-bit access; 0 = byte access (refused) |
| bus_addr | input | 3 | Register address (0..3 general, 4 control, 5 flags, 6 counter) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| cap_in | input | 4 | Capture input pins, asynchronous |
| cmp_out | output | 4 | Compare output pins, registered |

## Verification
Two pairs of functions can land on the same clock edge. In the first, a compare match sets a flag on the same edge where software writes 0 to that flag. The bench provokes this by loading the counter with a register's value and then raising `cnt_en` in the very cycle that carries the clearing write. The flag must read 1 while the other written-zero flags read 0. In the second, a capture edge arrives on the edge where a bus write targets the same register. The bench counts the synchroniser delay so that the write strobe sits exactly on the capture edge, then expects the counter value rather than the written data.

// File: rtl/ccr_pkg.sv
package ccr_pkg;

  typedef enum logic [1:0] {
    ACT_KEEP   = 2'b00,
    ACT_LOW    = 2'b01,
    ACT_HIGH   = 2'b10,
    ACT_TOGGLE = 2'b11
  } cmp_act_e;

  // Capture edge choice: 00 rising, 01 falling, 1x both
  function automatic logic edge_selected(input logic [1:0] sel,
                                         input logic       rise,
                                         input logic       fall);
    logic hit;
    if (sel[1])      hit = rise | fall;
    else if (sel[0]) hit = fall;
    else             hit = rise;
    return hit;
  endfunction

  function automatic logic act_level(input cmp_act_e act, input logic cur);
    logic lvl;
    case (act)
      ACT_LOW:    lvl = 1'b0;
      ACT_HIGH:   lvl = 1'b1;
      ACT_TOGGLE: lvl = ~cur;
      default:    lvl = cur;
    endcase
    return lvl;
  endfunction

endpackage

// File: rtl/ccr_counter.sv
module ccr_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  output logic [W-1:0] count
);

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (ld)      cnt_d = ld_val;
    else if (en) cnt_d = cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign count = cnt_q;

endmodule

// File: rtl/ccr_edge_det.sv
module ccr_edge_det #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise,
  output logic fall
);

  // stages 0..SYNC-1 synchronise, stage SYNC holds the previous sample
  logic [SYNC:0] sh_q, sh_d;

  always_comb sh_d = {sh_q[SYNC-1:0], pin};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rise =  sh_q[SYNC-1] & ~sh_q[SYNC];
  assign fall = ~sh_q[SYNC-1] &  sh_q[SYNC];

endmodule

// File: rtl/ccr_slot.sv
module ccr_slot
  import ccr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cnt,
  input  logic         cnt_en,
  input  logic         pwm,
  input  logic [2:0]   ctl,
  input  logic         rise,
  input  logic         fall,
  input  logic         wr_val,
  input  logic [W-1:0] wr_data,
  input  logic         flag_clr,
  output logic [W-1:0] value,
  output logic         flag,
  output logic         pin_out
);

  logic [W-1:0] gr_q, gr_d;
  logic         flag_q, flag_d;
  logic         out_q, out_d;
  logic         cap_mode, cap_evt, cmp_evt;

  always_comb begin
    cap_mode = ~pwm & ctl[2];
    cap_evt  = cap_mode & edge_selected(ctl[1:0], rise, fall);
    cmp_evt  = ~cap_mode & cnt_en & (cnt == gr_q);

    gr_d = gr_q;
    if (cap_evt)     gr_d = cnt;
    else if (wr_val) gr_d = wr_data;

    flag_d = flag_q;
    if (cap_evt | cmp_evt) flag_d = 1'b1;
    else if (flag_clr)     flag_d = 1'b0;

    out_d = out_q;
    if (pwm)          out_d = (cnt < gr_q);
    else if (cmp_evt) out_d = act_level(cmp_act_e'(ctl[1:0]), out_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gr_q   <= '1;
      flag_q <= 1'b0;
      out_q  <= 1'b0;
    end else begin
      gr_q   <= gr_d;
      flag_q <= flag_d;
      out_q  <= out_d;
    end
  end

  assign value   = gr_q;
  assign flag    = flag_q;
  assign pin_out = out_q;

endmodule

// File: rtl/ccr_bank.sv
module ccr_bank #(
  parameter int W    = 16,
  parameter int N    = 4,
  parameter int SYNC = 2,
  parameter int AW   = $clog2(N + 3)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cnt_en,
  input  logic          pwm_mode,
  input  logic          bus_we,
  input  logic          bus_full,
  input  logic [AW-1:0] bus_addr,
  input  logic [W-1:0]  bus_wdata,
  output logic [W-1:0]  bus_rdata,
  input  logic [N-1:0]  cap_in,
  output logic [N-1:0]  cmp_out
);

  localparam logic [AW-1:0] A_CTL  = AW'(N);
  localparam logic [AW-1:0] A_FLAG = AW'(N + 1);
  localparam logic [AW-1:0] A_CNT  = AW'(N + 2);

  logic                  wr_ok;
  logic [W-1:0]          cnt;
  logic [W-1:0]          ctl_q, ctl_d;
  logic [N-1:0][W-1:0]   gr_vec;
  logic [N-1:0]          flags;
  logic [N-1:0]          rise, fall;

  assign wr_ok = bus_we & bus_full;

  ccr_counter #(.W(W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (cnt_en),
    .ld    (wr_ok && bus_addr == A_CNT),
    .ld_val(bus_wdata),
    .count (cnt)
  );

  always_comb begin
    ctl_d = ctl_q;
    if (wr_ok && bus_addr == A_CTL) ctl_d = bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= '0;
    else        ctl_q <= ctl_d;
  end

  for (genvar k = 0; k < N; k++) begin : g_slot
    localparam logic [AW-1:0] A_GR = AW'(k);

    ccr_edge_det #(.SYNC(SYNC)) u_edge (
      .clk  (clk),
      .rst_n(rst_n),
      .pin  (cap_in[k]),
      .rise (rise[k]),
      .fall (fall[k])
    );

    ccr_slot #(.W(W)) u_slot (
      .clk     (clk),
      .rst_n   (rst_n),
      .cnt     (cnt),
      .cnt_en  (cnt_en),
      .pwm     (pwm_mode),
      .ctl     (ctl_q[4*k +: 3]),
      .rise    (rise[k]),
      .fall    (fall[k]),
      .wr_val  (wr_ok && bus_addr == A_GR),
      .wr_data (bus_wdata),
      .flag_clr(wr_ok && bus_addr == A_FLAG && !bus_wdata[k]),
      .value   (gr_vec[k]),
      .flag    (flags[k]),
      .pin_out (cmp_out[k])
    );
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == A_CTL)       bus_rdata = ctl_q;
    else if (bus_addr == A_FLAG) bus_rdata = W'(flags);
    else if (bus_addr == A_CNT)  bus_rdata = cnt;
    else begin
      for (int i = 0; i < N; i++)
        if (bus_addr == AW'(i)) bus_rdata = gr_vec[i];
    end
  end

endmodule

// File: rtl/ccr_bank_chk.sv
module ccr_bank_chk #(
  parameter int W  = 16,
  parameter int N  = 4,
  parameter int AW = 3
) (
  input logic                clk,
  input logic                rst_n,
  input logic                cnt_en,
  input logic                pwm_mode,
  input logic                bus_we,
  input logic                bus_full,
  input logic [AW-1:0]       bus_addr,
  input logic [W-1:0]        bus_wdata,
  input logic [W-1:0]        cnt,
  input logic [W-1:0]        ctl_q,
  input logic [N-1:0][W-1:0] gr_vec,
  input logic [N-1:0]        flags,
  input logic [N-1:0]        cmp_out
);

  logic cnt_load;
  assign cnt_load = bus_we && bus_full && bus_addr == AW'(N + 2);

  a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && !cnt_load) |=> cnt == $past(cnt) + W'(1));

  a_r2_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_en && !cnt_load) |=> $stable(cnt));

  a_r3_byte_refused: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && !bus_full) |=> $stable(ctl_q));

  a_r4_match_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && cnt == gr_vec[0] && (pwm_mode || !ctl_q[2])) |=> flags[0]);

  a_r8_flag_falls_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flags[0]) |-> $past(bus_we && bus_full && bus_addr == AW'(N + 1) && !bus_wdata[0]));

  a_r10_pwm_level: assert property (@(posedge clk) disable iff (!rst_n)
    pwm_mode |=> cmp_out[0] == ($past(cnt) < $past(gr_vec[0])));

endmodule

bind ccr_bank ccr_bank_chk #(.W(W), .N(N), .AW(AW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cnt_en   (cnt_en),
  .pwm_mode (pwm_mode),
  .bus_we   (bus_we),
  .bus_full (bus_full),
  .bus_addr (bus_addr),
  .bus_wdata(bus_wdata),
  .cnt      (cnt),
  .ctl_q    (ctl_q),
  .gr_vec   (gr_vec),
  .flags    (flags),
  .cmp_out  (cmp_out)
);

// File: tb/ccr_bank_tb.sv
module ccr_bank_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cnt_en = 1'b0;
  logic        pwm_mode = 1'b0;
  logic        bus_we = 1'b0;
  logic        bus_full = 1'b1;
  logic [2:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [3:0]  cap_in = '0;
  logic [3:0]  cmp_out;

  int checks = 0;
  int fails  = 0;
  logic [15:0] ctl_w = '0;
  logic [15:0] rv;

  always #(CLK_PERIOD/2) clk = ~clk;

  ccr_bank u_dut (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .pwm_mode(pwm_mode),
    .bus_we(bus_we), .bus_full(bus_full), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cap_in(cap_in), .cmp_out(cmp_out)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d, input logic full = 1'b1);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d; bus_full = full;
    @(negedge clk);
    bus_we = 1'b0; bus_full = 1'b1;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic run(input int n);
    @(negedge clk);
    cnt_en = 1'b1;
    repeat (n) @(negedge clk);
    cnt_en = 1'b0;
  endtask

  task automatic set_ctl(input int k, input logic [2:0] f);
    ctl_w[4*k +: 3] = f;
    wr(3'd4, ctl_w);
  endtask

  task automatic pin_and_wait(input int k, input logic v);
    @(negedge clk);
    cap_in[k] = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset;
    for (int i = 0; i < 4; i++) begin
      rd(3'(i), rv); check("R1 general reg", rv, 16'hFFFF);
    end
    rd(3'd4, rv); check("R1 control", rv, 16'h0000);
    rd(3'd5, rv); check("R1 flags", rv, 16'h0000);
    rd(3'd6, rv); check("R1 counter", rv, 16'h0000);
    check("R1 outputs", {12'h0, cmp_out}, 16'h0000);
  endtask

  task automatic t_wrap;
    wr(3'd6, 16'hFFFE);
    run(1);
    rd(3'd6, rv); check("R2 count step", rv, 16'hFFFF);
    run(1);
    rd(3'd6, rv); check("R2 wrap", rv, 16'h0000);
    rd(3'd5, rv); check("R4 reset regs match FFFF", rv, 16'h000F);
    wr(3'd5, 16'h0005);
    rd(3'd5, rv); check("R8 write-1 keeps, write-0 clears", rv, 16'h0005);
    wr(3'd5, 16'h0000);
    rd(3'd5, rv); check("R8 clear all", rv, 16'h0000);
  endtask

  task automatic t_bytes;
    wr(3'd3, 16'h1357);
    rd(3'd3, rv); check("R3 full write", rv, 16'h1357);
    wr(3'd3, 16'h2468, 1'b0);
    rd(3'd3, rv); check("R3 byte write refused", rv, 16'h1357);
    wr(3'd4, 16'h0777, 1'b0);
    rd(3'd4, rv); check("R3 byte control refused", rv, 16'h0000);
    wr(3'd6, 16'h4444, 1'b0);
    rd(3'd6, rv); check("R3 byte counter refused", rv, 16'h0000);
  endtask

  task automatic t_compare;
    wr(3'd0, 16'h0102);
    set_ctl(0, 3'b011);
    wr(3'd6, 16'h0100);
    run(2);
    rd(3'd5, rv); check("R4 no flag before match", rv & 16'h1, 16'h0);
    run(1);
    rd(3'd5, rv); check("R4 flag after match", rv & 16'h1, 16'h1);
    check("R5 toggle on match", {15'h0, cmp_out[0]}, 16'h1);
    rd(3'd6, rv); check("R2 counter after run", rv, 16'h0103);
  endtask

  task automatic t_actions;
    logic [1:0] acts [6];
    logic       exps [6];
    acts = '{2'b10, 2'b01, 2'b11, 2'b11, 2'b10, 2'b00};
    exps = '{1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1};
    wr(3'd1, 16'h0010);
    for (int i = 0; i < 6; i++) begin
      set_ctl(1, {1'b0, acts[i]});
      wr(3'd6, 16'h0010);
      run(1);
      check($sformatf("R5 action %b", acts[i]), {15'h0, cmp_out[1]}, {15'h0, exps[i]});
    end
  endtask

  task automatic t_capture;
    set_ctl(2, 3'b100);
    wr(3'd6, 16'h1234);
    pin_and_wait(2, 1'b1);
    rd(3'd2, rv); check("R6 rising capture", rv, 16'h1234);
    rd(3'd5, rv); check("R6 capture flag", rv & 16'h4, 16'h4);
    wr(3'd6, 16'h2222);
    repeat (4) @(negedge clk);
    rd(3'd2, rv); check("R7 steady level no recapture", rv, 16'h1234);
    pin_and_wait(2, 1'b0);
    rd(3'd2, rv); check("R6 falling ignored in rising mode", rv, 16'h1234);
    set_ctl(2, 3'b101);
    wr(3'd6, 16'h3333);
    pin_and_wait(2, 1'b1);
    rd(3'd2, rv); check("R6 rising ignored in falling mode", rv, 16'h1234);
    pin_and_wait(2, 1'b0);
    rd(3'd2, rv); check("R6 falling capture", rv, 16'h3333);
    set_ctl(2, 3'b110);
    wr(3'd6, 16'h4444);
    pin_and_wait(2, 1'b1);
    rd(3'd2, rv); check("R6 both-edge rise", rv, 16'h4444);
    wr(3'd6, 16'h5555);
    pin_and_wait(2, 1'b0);
    rd(3'd2, rv); check("R6 both-edge fall", rv, 16'h5555);
  endtask

  task automatic t_set_wins;
    wr(3'd3, 16'h0050);
    wr(3'd6, 16'h0050);
    @(negedge clk);
    cnt_en = 1'b1; bus_we = 1'b1; bus_addr = 3'd5; bus_wdata = 16'h0000; bus_full = 1'b1;
    @(negedge clk);
    cnt_en = 1'b0; bus_we = 1'b0;
    rd(3'd5, rv); check("R9 set beats clear", rv, 16'h0008);
  endtask

  task automatic t_cap_vs_write;
    wr(3'd6, 16'h6000);
    @(negedge clk); cap_in[2] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = 3'd2; bus_wdata = 16'hAAAA; bus_full = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
    rd(3'd2, rv); check("R11 capture beats bus write", rv, 16'h6000);
  endtask

  task automatic t_pwm;
    set_ctl(0, 3'b100);
    wr(3'd0, 16'h0005);
    wr(3'd6, 16'h0003);
    @(negedge clk); pwm_mode = 1'b1;
    @(negedge clk);
    check("R10 level below", {15'h0, cmp_out[0]}, 16'h1);
    wr(3'd5, 16'h0000);
    wr(3'd6, 16'h0004);
    run(2);
    rd(3'd5, rv); check("R10 match flag with capture field ignored", rv & 16'h1, 16'h1);
    check("R10 level not below", {15'h0, cmp_out[0]}, 16'h0);
    pin_and_wait(0, 1'b1);
    rd(3'd0, rv); check("R10 no capture in PWM", rv, 16'h0005);
    @(negedge clk); pwm_mode = 1'b0;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_wrap();
    t_bytes();
    t_compare();
    t_actions();
    t_capture();
    t_set_wins();
    t_cap_vs_write();
    t_pwm();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule